// File: doc/BRIEF.md
# Asynchronous Processor Bus Register Slave

This block answers register accesses from a microprocessor on an asynchronous, strobe-based bus. The host pulls chip select low and presents read/write, a byte address and a two-bit transfer-size code, then pulls the data strobe low. The slave brings chip select, strobe and read/write into its own clock domain through two-stage synchronisers. It pulls wait low while the access runs. When the access is done it releases wait and pulls either acknowledge or bus-error low. The data bus and the three handshake lines each have an output enable, so the pad ring can float them.

The cycle ends in stages. When the strobe rises, acknowledge and error return high, but the lines stay driven, and read data stays on the bus. Everything floats only after chip select rises. If chip select rises while the strobe is still low, the handshake lines are first driven high for at least one cycle and only then floated. One configuration input selects a 32-bit or a 16-bit data bus. A second input selects an alternate acknowledge style, in which acknowledge is pulled low at the end of every cycle, even one that reports an error.

The register array is small and word-organised. Accesses outside it, and size codes that are not legal for the current bus width, are reported as bus errors and write nothing.

Top module: `cpu_bus_slave`

## Requirements
- R1: After reset, `ctl_oe_o` and `data_oe_o` are 0 and `wait_no_o`, `dta_no_o` and `berr_no_o` are 1. Register i holds 32'h1000_0000 + i*32'h0001_0001.
- R2: Once chip select and strobe are both low (after two synchroniser stages), `ctl_oe_o` is 1 and `wait_no_o` is low for exactly ACC_LAT cycles (default 2). Acknowledge or error goes low only after wait has been low.
- R3: For a read in 32-bit mode, completion drives `dta_no_o` low and `data_oe_o` high, and `rdata_o` carries the whole word at index addr[AW-1:2]. All 32 lines are driven whatever the size code.
- R4: The size code selects the bytes written. In 32-bit mode, 11 writes the whole word, 10 and 01 write the halfword chosen by addr[1] (bits 31:16 when addr[1]=1), and 00 writes the byte at lane addr[1:0]. Write data sits on its natural lanes.
- R5: An access whose word index is NUM_REGS or more completes with `berr_no_o` low and `dta_no_o` high (normal mode) and writes nothing.
- R6: A size that does not fit the bus mode or alignment is a bus error and writes nothing. Such sizes are: a word (11) with addr[1:0] not 00 in 32-bit mode, a halfword with addr[0]=1 in 32-bit mode, and size 11 in 16-bit mode.
- R7: In 16-bit mode (`half_mode_i`=1), addr[0] is ignored. A read returns the halfword chosen by addr[1] on `rdata_o[15:0]`, with `rdata_o[31:16]` driven 0. A write takes its data from `wdata_i[15:0]`. Size 10/01 writes the selected halfword, and size 00 writes the low byte of the selected halfword.
- R8: When the strobe rises while chip select stays low, acknowledge and error return high but stay driven, and read data stays driven. Both enables fall once chip select rises.
- R9: When chip select rises before the strobe, wait, acknowledge and error are driven high for at least one cycle before `ctl_oe_o` falls.
- R10: With `alt_ack_i`=1, `dta_no_o` goes low at completion of every cycle, including error cycles, where `berr_no_o` is low as well.
- R11: In normal mode acknowledge and error are never low together, and neither is low while wait is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| ds_ni | input | 1 | Data strobe, active low, asynchronous |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | AW | Byte address |
| size_i | input | 2 | Transfer size: 00 byte, 01/10 halfword, 11 word |
| wdata_i | input | 32 | Write data |
| half_mode_i | input | 1 | 1 = 16-bit data bus |
| alt_ack_i | input | 1 | 1 = acknowledge on every completion |
| rdata_o | output | 32 | Read data |
| data_oe_o | output | 1 | Data bus output enable |
| wait_no_o | output | 1 | Wait, active low |
| dta_no_o | output | 1 | Data acknowledge, active low |
| berr_no_o | output | 1 | Bus error, active low |
| ctl_oe_o | output | 1 | Output enable for wait, acknowledge and error |

## Verification
Some rules hold on every cycle, and the assertions check those. They cover acknowledge and error never being low together outside the alternate mode, wait excluding both, and the data enable implying the handshake enable. They also cover the handshake lines being all high in the cycle before they float, completion being preceded by wait, the alternate mode acknowledging error cycles, and the upper lines being zero in 16-bit mode. Other behaviour needs end-to-end scenarios, and only the bench's scenarios show it. That includes register contents and lane merging under each size code, error decode for range and alignment, the exact wait length, and the staged release under both orderings of strobe and chip select.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_ACK,
    ST_WAIT_DS_HIGH,
    ST_RELEASE
  } bus_st_e;

  localparam logic [1:0] SZ_BYTE   = 2'b00;
  localparam logic [1:0] SZ_HALF_A = 2'b01;
  localparam logic [1:0] SZ_HALF_B = 2'b10;
  localparam logic [1:0] SZ_WORD   = 2'b11;

  typedef struct packed {
    logic       err;
    logic [3:0] lane_en;
  } xfer_dec_t;
endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode
  import cbs_pkg::*;
#(
  parameter int AW       = 8,
  parameter int NUM_REGS = 8,
  localparam int IW      = AW - 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          half_mode_i,
  output logic [IW-1:0] idx_o,
  output xfer_dec_t     dec_o
);
  logic misalign, out_of_range;

  assign idx_o        = addr_i[AW-1:2];
  assign out_of_range = ({{(32-IW){1'b0}}, idx_o} >= 32'(NUM_REGS));

  always_comb begin
    misalign      = 1'b0;
    dec_o.lane_en = 4'b0000;
    if (half_mode_i) begin
      unique case (size_i)
        SZ_WORD:             misalign = 1'b1;
        SZ_HALF_A, SZ_HALF_B: dec_o.lane_en = addr_i[1] ? 4'b1100 : 4'b0011;
        default:             dec_o.lane_en = addr_i[1] ? 4'b0100 : 4'b0001;
      endcase
    end else begin
      unique case (size_i)
        SZ_WORD: begin
          misalign      = (addr_i[1:0] != 2'b00);
          dec_o.lane_en = 4'b1111;
        end
        SZ_HALF_A, SZ_HALF_B: begin
          misalign      = addr_i[0];
          dec_o.lane_en = addr_i[1] ? 4'b1100 : 4'b0011;
        end
        default: dec_o.lane_en = 4'b0001 << addr_i[1:0];
      endcase
    end
    dec_o.err = misalign | out_of_range;
  end
endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile #(
  parameter int          NUM_REGS = 8,
  parameter int          IW       = 6,
  parameter logic [31:0] RST_BASE = 32'h1000_0000,
  parameter logic [31:0] RST_STEP = 32'h0001_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [3:0]    lane_en_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [31:0] RST_VAL = RST_BASE + RST_STEP * 32'(i);
    logic hit;
    assign hit = we_i && (idx_i == IW'(i));
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  regs_q[i][8*b +: 8] <= RST_VAL[8*b +: 8];
        else if (hit && lane_en_i[b]) regs_q[i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_i == IW'(i)) rdata_o = regs_q[i];
    end
  end
endmodule

// File: rtl/cbs_fsm.sv
module cbs_fsm
  import cbs_pkg::*;
#(
  parameter int ACC_LAT = 2,
  localparam int CW     = $clog2(ACC_LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_act_i,
  input  logic ds_act_i,
  input  logic rd_i,
  input  logic alt_ack_i,
  input  logic err_i,
  output logic launch_o,
  output logic rd_o,
  output logic wait_no_o,
  output logic dta_no_o,
  output logic berr_no_o,
  output logic ctl_oe_o,
  output logic data_oe_o
);
  bus_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          rd_q, err_q, start;

  assign start    = cs_act_i && ds_act_i;
  assign launch_o = (st_q == ST_ACCESS) && cs_act_i && (cnt_q == CW'(ACC_LAT - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:         if (start) st_d = ST_ACCESS;
      ST_ACCESS: begin
        if (!cs_act_i)    st_d = ST_RELEASE;
        else if (launch_o) st_d = ST_ACK;
      end
      ST_ACK:          st_d = (cs_act_i && ds_act_i) ? ST_WAIT_DS_HIGH : ST_RELEASE;
      ST_WAIT_DS_HIGH: if (!cs_act_i || !ds_act_i) st_d = ST_RELEASE;
      ST_RELEASE: begin
        if (!cs_act_i)     st_d = ST_IDLE;
        else if (ds_act_i) st_d = ST_ACCESS;  // back-to-back strobe
      end
      default:         st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rd_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_ACCESS && st_q != ST_ACCESS) begin
        cnt_q <= '0;
        rd_q  <= rd_i;
      end else if (st_q == ST_ACCESS) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (launch_o) err_q <= err_i;
    end
  end

  logic ack_st;
  assign ack_st    = (st_q == ST_ACK) || (st_q == ST_WAIT_DS_HIGH);
  assign rd_o      = rd_q;
  assign ctl_oe_o  = (st_q != ST_IDLE);
  assign wait_no_o = (st_q != ST_ACCESS);
  assign berr_no_o = !(ack_st && err_q);
  assign dta_no_o  = !(ack_st && (!err_q || alt_ack_i));
  assign data_oe_o = rd_q && (ack_st || st_q == ST_RELEASE);
endmodule

// File: rtl/cpu_bus_slave.sv
module cpu_bus_slave
  import cbs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          NUM_REGS = 8,
  parameter int          ACC_LAT  = 2,
  parameter logic [31:0] RST_BASE = 32'h1000_0000,
  parameter logic [31:0] RST_STEP = 32'h0001_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [31:0]   wdata_i,
  input  logic          half_mode_i,
  input  logic          alt_ack_i,
  output logic [31:0]   rdata_o,
  output logic          data_oe_o,
  output logic          wait_no_o,
  output logic          dta_no_o,
  output logic          berr_no_o,
  output logic          ctl_oe_o
);
  localparam int IW = AW - 2;

  logic [2:0]    sync_q;
  logic          cs_act, ds_act, rd_sync, launch, rd_cyc;
  logic [IW-1:0] idx;
  xfer_dec_t     dec;
  logic [31:0]   wr_data, word, rd_mux, rdata_q;

  cbs_sync #(.W(3), .RST(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, ds_ni, rw_i}),
    .q_o   (sync_q)
  );

  assign cs_act  = !sync_q[2];
  assign ds_act  = !sync_q[1];
  assign rd_sync = sync_q[0];

  cbs_decode #(.AW(AW), .NUM_REGS(NUM_REGS)) u_dec (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .half_mode_i(half_mode_i),
    .idx_o      (idx),
    .dec_o      (dec)
  );

  assign wr_data = half_mode_i ? {wdata_i[15:0], wdata_i[15:0]} : wdata_i;

  cbs_regfile #(
    .NUM_REGS(NUM_REGS), .IW(IW), .RST_BASE(RST_BASE), .RST_STEP(RST_STEP)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (launch && !rd_cyc && !dec.err),
    .idx_i    (idx),
    .lane_en_i(dec.lane_en),
    .wdata_i  (wr_data),
    .rdata_o  (word)
  );

  cbs_fsm #(.ACC_LAT(ACC_LAT)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .ds_act_i (ds_act),
    .rd_i     (rd_sync),
    .alt_ack_i(alt_ack_i),
    .err_i    (dec.err),
    .launch_o (launch),
    .rd_o     (rd_cyc),
    .wait_no_o(wait_no_o),
    .dta_no_o (dta_no_o),
    .berr_no_o(berr_no_o),
    .ctl_oe_o (ctl_oe_o),
    .data_oe_o(data_oe_o)
  );

  assign rd_mux = half_mode_i ? {16'h0000, (addr_i[1] ? word[31:16] : word[15:0])} : word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (launch && rd_cyc) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/cpu_bus_slave_checks.sv
module cpu_bus_slave_checks (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        half_mode_i,
  input logic        alt_ack_i,
  input logic [31:0] rdata_o,
  input logic        data_oe_o,
  input logic        wait_no_o,
  input logic        dta_no_o,
  input logic        berr_no_o,
  input logic        ctl_oe_o
);
  assert_no_dual_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dta_no_o && !berr_no_o) |-> alt_ack_i);

  assert_wait_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_no_o |-> (dta_no_o && berr_no_o));

  assert_wait_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dta_no_o) || $fell(berr_no_o)) |-> $past(!wait_no_o));

  assert_data_in_ctl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> ctl_oe_o);

  assert_high_before_float_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_oe_o) |-> $past(wait_no_o && dta_no_o && berr_no_o));

  assert_alt_ack_on_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && !berr_no_o && alt_ack_i) |-> !dta_no_o);

  assert_half_upper_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && half_mode_i) |-> (rdata_o[31:16] == 16'h0000));
endmodule

bind cpu_bus_slave cpu_bus_slave_checks u_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .half_mode_i(half_mode_i),
  .alt_ack_i  (alt_ack_i),
  .rdata_o    (rdata_o),
  .data_oe_o  (data_oe_o),
  .wait_no_o  (wait_no_o),
  .dta_no_o   (dta_no_o),
  .berr_no_o  (berr_no_o),
  .ctl_oe_o   (ctl_oe_o)
);

// File: tb/cpu_bus_slave_test.sv
module cpu_bus_slave_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [1:0]  size_i = 2'b11;
  logic [31:0] wdata_i = '0;
  logic        half_mode_i = 1'b0, alt_ack_i = 1'b0;
  logic [31:0] rdata_o;
  logic        data_oe_o, wait_no_o, dta_no_o, berr_no_o, ctl_oe_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cpu_bus_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ds_ni(ds_ni), .rw_i(rw_i),
    .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
    .half_mode_i(half_mode_i), .alt_ack_i(alt_ack_i),
    .rdata_o(rdata_o), .data_oe_o(data_oe_o), .wait_no_o(wait_no_o),
    .dta_no_o(dta_no_o), .berr_no_o(berr_no_o), .ctl_oe_o(ctl_oe_o)
  );

  function automatic logic [31:0] rst_val(input int i);
    return 32'h1000_0000 + 32'h0001_0001 * 32'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access with strobe released before chip select; checks staged release (R8).
  task automatic bus_cycle(input logic rw, input logic [7:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, output logic [31:0] rd,
                           output logic dta, output logic berr, output int lowcnt);
    logic done = 1'b0;
    @(negedge clk);
    rw_i = rw; addr_i = a; size_i = sz; wdata_i = wd;
    cs_ni = 1'b0; ds_ni = 1'b0;
    lowcnt = 0; rd = '0; dta = 1'b1; berr = 1'b1;
    for (int k = 0; k < 40 && !done; k++) begin
      @(negedge clk);
      if (!wait_no_o) lowcnt++;
      if (!dta_no_o || !berr_no_o) begin
        done = 1'b1; rd = rdata_o; dta = dta_no_o; berr = berr_no_o;
        chk("R3 data_oe at completion", 32'(data_oe_o), 32'(rw));
      end
    end
    chk("R2 completion seen", 32'(done), 32'd1);
    ds_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 ctl still driven after strobe high", 32'(ctl_oe_o), 32'd1);
    chk("R8 handshake high after strobe high", {29'd0, wait_no_o, dta_no_o, berr_no_o}, 32'd7);
    chk("R8 data still driven after strobe high", 32'(data_oe_o), 32'(rw));
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 all floated after cs high", {30'd0, ctl_oe_o, data_oe_o}, 32'd0);
  endtask

  task automatic read_exp(input string tag, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
    logic [31:0] rd; logic dta, berr; int lc;
    bus_cycle(1'b1, a, sz, '0, rd, dta, berr, lc);
    chk({tag, " ack"}, {30'd0, dta, berr}, 32'd1);
    chk({tag, " data"}, rd, exp);
  endtask

  task automatic write_exp(input string tag, input logic [7:0] a, input logic [1:0] sz,
                           input logic [31:0] wd, input logic exp_err);
    logic [31:0] rd; logic dta, berr; int lc;
    bus_cycle(1'b0, a, sz, wd, rd, dta, berr, lc);
    chk({tag, " handshake"}, {30'd0, dta, berr}, exp_err ? 32'd2 : 32'd1);
  endtask

  task automatic test_reset;
    chk("R1 enables after reset", {30'd0, ctl_oe_o, data_oe_o}, 32'd0);
    chk("R1 handshake levels after reset", {29'd0, wait_no_o, dta_no_o, berr_no_o}, 32'd7);
    for (int i = 0; i < 8; i++) read_exp("R1 R3 reset value", 8'(4 * i), 2'b11, rst_val(i));
  endtask

  task automatic test_wait_len;
    logic [31:0] rd; logic dta, berr; int lc;
    bus_cycle(1'b1, 8'h08, 2'b11, '0, rd, dta, berr, lc);
    chk("R2 wait low cycles", 32'(lc), 32'd2);
    chk("R3 read word 2", rd, rst_val(2));
  endtask

  task automatic test_lanes;
    write_exp("R4 word write", 8'h04, 2'b11, 32'hDEAD_BEEF, 1'b0);
    read_exp("R4 word readback", 8'h04, 2'b11, 32'hDEAD_BEEF);
    write_exp("R4 upper half size10", 8'h06, 2'b10, 32'h1234_0000, 1'b0);
    read_exp("R4 upper half readback", 8'h04, 2'b01, 32'h1234_BEEF);
    write_exp("R4 lower half size01", 8'h04, 2'b01, 32'h0000_5678, 1'b0);
    read_exp("R4 lower half readback", 8'h04, 2'b11, 32'h1234_5678);
    write_exp("R4 byte lane3", 8'h07, 2'b00, 32'hAB00_0000, 1'b0);
    read_exp("R4 byte readback", 8'h04, 2'b11, 32'hAB34_5678);
  endtask

  task automatic test_range;
    logic [31:0] rd; logic dta, berr; int lc;
    bus_cycle(1'b1, 8'h20, 2'b11, '0, rd, dta, berr, lc);
    chk("R5 read beyond array", {30'd0, dta, berr}, 32'd2);
    write_exp("R5 write beyond array", 8'hFC, 2'b11, 32'hFFFF_FFFF, 1'b1);
    read_exp("R5 last reg untouched", 8'h1C, 2'b11, rst_val(7));
  endtask

  task automatic test_align;
    write_exp("R6 misaligned word", 8'h09, 2'b11, 32'h5555_5555, 1'b1);
    write_exp("R6 odd halfword", 8'h0B, 2'b10, 32'h6666_6666, 1'b1);
    read_exp("R6 reg2 untouched", 8'h08, 2'b11, rst_val(2));
    half_mode_i = 1'b1;
    write_exp("R6 word size in 16-bit mode", 8'h08, 2'b11, 32'h0000_7777, 1'b1);
    half_mode_i = 1'b0;
    read_exp("R6 reg2 untouched 16-bit", 8'h08, 2'b11, rst_val(2));
  endtask

  task automatic test_half;
    half_mode_i = 1'b1;
    read_exp("R7 upper half addr6", 8'h06, 2'b10, 32'h0000_AB34);
    read_exp("R7 addr0 ignored", 8'h07, 2'b01, 32'h0000_AB34);
    read_exp("R7 lower half", 8'h05, 2'b10, 32'h0000_5678);
    write_exp("R7 half write", 8'h0C, 2'b10, 32'hFFFF_9999, 1'b0);
    write_exp("R7 byte write", 8'h0F, 2'b00, 32'h0000_0077, 1'b0);
    half_mode_i = 1'b0;
    read_exp("R7 reg3 merged", 8'h0C, 2'b11, 32'h1077_9999);
  endtask

  task automatic test_cs_first;
    logic done = 1'b0;
    logic [2:0] last = 3'b000;
    logic floated = 1'b0;
    @(negedge clk);
    rw_i = 1'b1; addr_i = 8'h00; size_i = 2'b11; cs_ni = 1'b0; ds_ni = 1'b0;
    for (int k = 0; k < 40 && !done; k++) begin
      @(negedge clk);
      if (!dta_no_o) done = 1'b1;
    end
    chk("R9 completion", 32'(done), 32'd1);
    cs_ni = 1'b1;
    for (int k = 0; k < 10 && !floated; k++) begin
      @(negedge clk);
      if (ctl_oe_o) last = {wait_no_o, dta_no_o, berr_no_o};
      else floated = 1'b1;
    end
    chk("R9 floated", 32'(floated), 32'd1);
    chk("R9 driven high before float", 32'(last), 32'd7);
    ds_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after", 32'(ctl_oe_o), 32'd0);
  endtask

  task automatic test_alt;
    logic [31:0] rd; logic dta, berr; int lc;
    alt_ack_i = 1'b1;
    bus_cycle(1'b1, 8'h40, 2'b11, '0, rd, dta, berr, lc);
    chk("R10 error cycle acks", {30'd0, dta, berr}, 32'd0);
    bus_cycle(1'b1, 8'h00, 2'b11, '0, rd, dta, berr, lc);
    chk("R10 good cycle", {30'd0, dta, berr}, 32'd1);
    alt_ack_i = 1'b0;
    bus_cycle(1'b1, 8'h40, 2'b11, '0, rd, dta, berr, lc);
    chk("R11 normal error no ack", {30'd0, dta, berr}, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_wait_len();
    test_lanes();
    test_range();
    test_align();
    test_half();
    test_cs_first();
    test_alt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule